// File: doc/BRIEF.md
# Power-Management Function Configuration Front End

This block sits at the configuration-space edge of a chipset power-management function. It keeps a small PCI-style configuration register file that accepts dword-addressed writes with per-byte enables and returns read data one cycle after a read request. Several bytes come up with fixed identity and default values. A few bits are read-only markers that software cannot clear.

Two relocatable I/O windows are derived from that register file. One is a 64-byte window for the PM register block and the other is for an SMBus controller. Each window has a page-aligned base and an enable bit. The block latches a window's base and enable only when a configuration write lands on one of the bytes that define that window. For every I/O cycle it reports a hit for each window whose enable is set and whose base page matches the address. The timer, event, GPE and SMBus engines sit outside this block and receive only these enable and hit signals.

The block also decodes writes to an APM command port. Two command codes turn the ACPI SCI-enable bit on and off. Any other code raises a level SMI request, but only while the SMI-generation bit in configuration is set. The request stays asserted until it is acknowledged.

Top module: `pm_cfg_front`

## Requirements
- R1: After reset, configuration reads return these values. Byte 0x06 is 0x80, byte 0x07 is 0x02 and byte 0x08 is the revision 0x03. Byte 0x3d is 0x01 and byte 0xd2 is 0x09. Byte 0x40 is 0x01 and byte 0x80 is 0x00. Bytes 0x58..0x5a are 0x00. The SMBus base dword at 0x90 holds SMB_BASE_INIT with its low six bits cleared and bit 0 set.
- R2: A write stores only the byte lanes whose bit in cfg_be is set. Lane n is byte dw*4+n and occupies cfg_wdata[8n+7:8n]. A read returns the dword on cfg_rdata one cycle after cfg_rd, and cfg_rdata holds that value while no read is issued.
- R3: Dwords 0x00..0x08 (identity, status, revision and class) and byte 0x3d ignore writes. Bit 0 of byte 0x40 and bit 0 of byte 0x90 always read as 1.
- R4: pm_base equals the 16-bit little-endian value at bytes 0x40..0x41 with bits [5:0] cleared. pm_en equals bit 0 of byte 0x80. Both change on the second clock edge after a write that touches byte 0x80 or any of bytes 0x40..0x43, and they do not change at any other time.
- R5: smb_base is taken from bytes 0x90..0x91 with bits [5:0] cleared, and smb_en is bit 0 of byte 0xd2. They are updated on the same schedule as the PM window, after writes that touch 0xd2 or 0x90..0x93. The SMBus window is enabled from reset.
- R6: One cycle after io_valid, pm_hit (or smb_hit) is 1 exactly when that window was enabled and io_addr[15:6] equalled its base page. Otherwise it is 0.
- R7: An APM write of 0xf1 sets sci_en on the next edge, and a write of 0xf0 clears it. Neither code raises smi.
- R8: An APM write of any other code sets smi on the next edge if bit 1 of byte 0x5b is 1. If that bit is 0, the write leaves smi at 0.
- R9: smi stays at 1 until smi_ack is sampled high. A new SMI-raising command takes priority over a simultaneous smi_ack.
- R10: Byte 0x5b resets to 0x02 when SMM_SUPPORT is 0, which enables APM-triggered SMI, and to 0x00 when SMM_SUPPORT is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw | input | DW_AW | Dword index of the configuration access |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Write data, little-endian lanes |
| cfg_rdata | output | 32 | Read data, valid one cycle after cfg_rd |
| io_valid | input | 1 | I/O cycle present |
| io_addr | input | IO_AW | I/O cycle address |
| pm_en | output | 1 | PM window enable |
| pm_base | output | IO_AW | PM window base |
| pm_hit | output | 1 | I/O cycle hit the PM window |
| smb_en | output | 1 | SMBus window enable |
| smb_base | output | IO_AW | SMBus window base |
| smb_hit | output | 1 | I/O cycle hit the SMBus window |
| apm_wr | input | 1 | APM command port write |
| apm_data | input | 8 | APM command code |
| smi_ack | input | 1 | Clears a pending SMI request |
| sci_en | output | 1 | ACPI SCI-enable control bit |
| smi | output | 1 | SMI request level |

## Verification
The bench builds two copies of the block. Both use a non-zero SMB_BASE_INIT of 0xb100 and non-default identity values, so the reset contents of the SMBus base and the identity dword can be told apart from zero-filled storage. The first copy uses SMM_SUPPORT=0, which makes APM-triggered SMI reachable from reset. The second uses SMM_SUPPORT=1, which shows byte 0x5b resetting to zero and the APM port staying silent for non-ACPI commands.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;

  // Dword indices whose position the window and SMI logic depend on
  localparam int DW_IDENT   = 0;   // bytes 0x00..0x03
  localparam int DW_STATUS  = 1;   // bytes 0x04..0x07
  localparam int DW_CLASS   = 2;   // bytes 0x08..0x0b
  localparam int DW_INTR    = 15;  // bytes 0x3c..0x3f
  localparam int DW_PMBASE  = 16;  // bytes 0x40..0x43
  localparam int DW_SMICTL  = 22;  // bytes 0x58..0x5b
  localparam int DW_PMEN    = 32;  // bytes 0x80..0x83
  localparam int DW_SMBBASE = 36;  // bytes 0x90..0x93
  localparam int DW_SMBEN   = 52;  // bytes 0xd0..0xd3

  localparam int MIN_DWORDS = DW_SMBEN + 1;

  localparam logic [7:0] APM_SCI_ON  = 8'hf1;
  localparam logic [7:0] APM_SCI_OFF = 8'hf0;

  // Bits of a configuration byte that a write may change
  function automatic logic [7:0] lane_wmask(int dw, int lane);
    logic [7:0] m;
    m = 8'hff;
    if (dw <= DW_CLASS)                     m = 8'h00;
    else if (dw == DW_INTR    && lane == 1) m = 8'h00;
    else if (dw == DW_PMBASE  && lane == 0) m = 8'hfe;
    else if (dw == DW_SMBBASE && lane == 0) m = 8'hfe;
    return m;
  endfunction

endpackage

// File: rtl/pm_cfg_regfile.sv
module pm_cfg_regfile
  import pm_cfg_pkg::*;
#(
  parameter int          CFG_DWORDS    = 64,
  parameter int          IO_AW         = 16,
  parameter bit          SMM_SUPPORT   = 1'b0,
  parameter logic [15:0] VENDOR_ID     = 16'h1d0f,
  parameter logic [15:0] DEVICE_ID     = 16'h0a55,
  parameter logic [7:0]  REVISION      = 8'h03,
  parameter logic [23:0] CLASS_CODE    = 24'h068000,
  parameter logic [15:0] SMB_BASE_INIT = 16'h0000,
  localparam int         DW_AW         = $clog2(CFG_DWORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [DW_AW-1:0] cfg_dw,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic [IO_AW-1:0] pm_base_word,
  output logic             pm_en_bit,
  output logic [IO_AW-1:0] smb_base_word,
  output logic             smb_en_bit,
  output logic             smi_gate
);

  function automatic logic [31:0] init_dword(int idx);
    logic [31:0] v;
    v = '0;
    case (idx)
      DW_IDENT:   v = {DEVICE_ID, VENDOR_ID};
      DW_STATUS:  v = 32'h0280_0000;
      DW_CLASS:   v = {CLASS_CODE, REVISION};
      DW_INTR:    v = 32'h0000_0100;
      DW_PMBASE:  v = 32'h0000_0001;
      DW_SMICTL:  v = SMM_SUPPORT ? 32'h0 : 32'h0200_0000;
      DW_SMBBASE: v = {16'h0, (SMB_BASE_INIT & 16'hffc0) | 16'h0001};
      DW_SMBEN:   v = 32'h0009_0000;
      default:    v = '0;
    endcase
    return v;
  endfunction

  logic [31:0] mem [CFG_DWORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CFG_DWORDS; i++) mem[i] <= init_dword(i);
    end else if (cfg_wr) begin
      for (int d = 0; d < CFG_DWORDS; d++) begin
        if (cfg_dw == DW_AW'(d)) begin
          for (int b = 0; b < 4; b++) begin
            if (cfg_be[b]) begin
              mem[d][8*b +: 8] <= (mem[d][8*b +: 8] & ~lane_wmask(d, b)) |
                                  (cfg_wdata[8*b +: 8] & lane_wmask(d, b));
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= mem[cfg_dw];
  end

  assign pm_base_word  = mem[DW_PMBASE][IO_AW-1:0];
  assign pm_en_bit     = mem[DW_PMEN][0];
  assign smb_base_word = mem[DW_SMBBASE][IO_AW-1:0];
  assign smb_en_bit    = mem[DW_SMBEN][16];
  assign smi_gate      = mem[DW_SMICTL][25];

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> $stable(cfg_rdata)); // R2
  AST_PM_MARKER: assert property (@(posedge clk) disable iff (rst)
    pm_base_word[0] == 1'b1); // R3
  AST_SMB_MARKER: assert property (@(posedge clk) disable iff (rst)
    smb_base_word[0] == 1'b1); // R3

endmodule

// File: rtl/pm_io_window.sv
module pm_io_window #(
  parameter int              IO_AW      = 16,
  parameter int              WIN_BITS   = 6,
  parameter logic [IO_AW-1:0] RESET_BASE = '0,
  parameter bit              RESET_EN   = 1'b0,
  localparam int             PG_W       = IO_AW - WIN_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [PG_W-1:0]  base_page,
  input  logic             en_bit,
  input  logic             io_valid,
  input  logic [PG_W-1:0]  io_page,
  output logic             win_en,
  output logic [IO_AW-1:0] win_base,
  output logic             hit
);

  logic            touch_q;
  logic [PG_W-1:0] page_q;
  logic            en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      touch_q <= 1'b0;
      page_q  <= RESET_BASE[IO_AW-1:WIN_BITS];
      en_q    <= RESET_EN;
      hit     <= 1'b0;
    end else begin
      touch_q <= touch;
      if (touch_q) begin
        page_q <= base_page;
        en_q   <= en_bit;
      end
      hit <= io_valid && en_q && (io_page == page_q);
    end
  end

  assign win_en   = en_q;
  assign win_base = {page_q, {WIN_BITS{1'b0}}};

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !touch_q |=> ($stable(page_q) && $stable(en_q))); // R4
  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(en_q)); // R6
  AST_HIT_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !io_valid |=> !hit); // R6

endmodule

// File: rtl/pm_apm_decoder.sv
module pm_apm_decoder #(
  parameter logic [7:0] CMD_ON  = 8'hf1,
  parameter logic [7:0] CMD_OFF = 8'hf0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       apm_wr,
  input  logic [7:0] apm_data,
  input  logic       smi_gate,
  input  logic       smi_ack,
  output logic       sci_en,
  output logic       smi
);

  logic is_on, is_off, raise;

  assign is_on  = apm_wr && (apm_data == CMD_ON);
  assign is_off = apm_wr && (apm_data == CMD_OFF);
  assign raise  = apm_wr && !is_on && !is_off && smi_gate;

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_en <= 1'b0;
      smi    <= 1'b0;
    end else begin
      if (is_on)       sci_en <= 1'b1;
      else if (is_off) sci_en <= 1'b0;
      if (raise)        smi <= 1'b1;
      else if (smi_ack) smi <= 1'b0;
    end
  end

  AST_SCI_SET: assert property (@(posedge clk) disable iff (rst)
    (apm_wr && apm_data == CMD_ON) |=> sci_en); // R7
  AST_SCI_CLR: assert property (@(posedge clk) disable iff (rst)
    (apm_wr && apm_data == CMD_OFF) |=> !sci_en); // R7
  AST_ACPI_NO_SMI: assert property (@(posedge clk) disable iff (rst)
    (apm_wr && (apm_data == CMD_ON || apm_data == CMD_OFF) && !smi) |=> !smi); // R7
  AST_SMI_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(smi) |-> $past(smi_gate && apm_wr)); // R8
  AST_SMI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (smi && !smi_ack) |=> smi); // R9

endmodule

// File: rtl/pm_cfg_front.sv
module pm_cfg_front
  import pm_cfg_pkg::*;
#(
  parameter int          CFG_DWORDS    = 64,
  parameter int          IO_AW         = 16,
  parameter int          WIN_BITS      = 6,
  parameter bit          SMM_SUPPORT   = 1'b0,
  parameter logic [15:0] VENDOR_ID     = 16'h1d0f,
  parameter logic [15:0] DEVICE_ID     = 16'h0a55,
  parameter logic [7:0]  REVISION      = 8'h03,
  parameter logic [23:0] CLASS_CODE    = 24'h068000,
  parameter logic [15:0] SMB_BASE_INIT = 16'h0000,
  localparam int         DW_AW         = $clog2(CFG_DWORDS),
  localparam int         PG_W          = IO_AW - WIN_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [DW_AW-1:0] cfg_dw,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             io_valid,
  input  logic [IO_AW-1:0] io_addr,
  output logic             pm_en,
  output logic [IO_AW-1:0] pm_base,
  output logic             pm_hit,
  output logic             smb_en,
  output logic [IO_AW-1:0] smb_base,
  output logic             smb_hit,
  input  logic             apm_wr,
  input  logic [7:0]       apm_data,
  input  logic             smi_ack,
  output logic             sci_en,
  output logic             smi
);

  initial begin
    if (CFG_DWORDS < MIN_DWORDS) $error("CFG_DWORDS too small for register layout");
    if (IO_AW > 16 || WIN_BITS >= IO_AW) $error("bad I/O window geometry");
  end

  logic [IO_AW-1:0] pm_base_word, smb_base_word;
  logic             pm_en_bit, smb_en_bit, smi_gate;
  logic             pm_touch, smb_touch;

  pm_cfg_regfile #(
    .CFG_DWORDS(CFG_DWORDS), .IO_AW(IO_AW), .SMM_SUPPORT(SMM_SUPPORT),
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .CLASS_CODE(CLASS_CODE), .SMB_BASE_INIT(SMB_BASE_INIT)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pm_base_word(pm_base_word), .pm_en_bit(pm_en_bit),
    .smb_base_word(smb_base_word), .smb_en_bit(smb_en_bit), .smi_gate(smi_gate)
  );

  // A window is re-latched only after a write that lands on its defining bytes
  assign pm_touch  = cfg_wr && ((cfg_dw == DW_AW'(DW_PMBASE) && |cfg_be) ||
                                (cfg_dw == DW_AW'(DW_PMEN)   && cfg_be[0]));
  assign smb_touch = cfg_wr && ((cfg_dw == DW_AW'(DW_SMBBASE) && |cfg_be) ||
                                (cfg_dw == DW_AW'(DW_SMBEN)   && cfg_be[2]));

  pm_io_window #(
    .IO_AW(IO_AW), .WIN_BITS(WIN_BITS),
    .RESET_BASE('0), .RESET_EN(1'b0)
  ) u_pm_win (
    .clk(clk), .rst(rst), .touch(pm_touch),
    .base_page(pm_base_word[IO_AW-1:WIN_BITS]), .en_bit(pm_en_bit),
    .io_valid(io_valid), .io_page(io_addr[IO_AW-1:WIN_BITS]),
    .win_en(pm_en), .win_base(pm_base), .hit(pm_hit)
  );

  pm_io_window #(
    .IO_AW(IO_AW), .WIN_BITS(WIN_BITS),
    .RESET_BASE(SMB_BASE_INIT[IO_AW-1:0]), .RESET_EN(1'b1)
  ) u_smb_win (
    .clk(clk), .rst(rst), .touch(smb_touch),
    .base_page(smb_base_word[IO_AW-1:WIN_BITS]), .en_bit(smb_en_bit),
    .io_valid(io_valid), .io_page(io_addr[IO_AW-1:WIN_BITS]),
    .win_en(smb_en), .win_base(smb_base), .hit(smb_hit)
  );

  pm_apm_decoder #(
    .CMD_ON(APM_SCI_ON), .CMD_OFF(APM_SCI_OFF)
  ) u_apm (
    .clk(clk), .rst(rst), .apm_wr(apm_wr), .apm_data(apm_data),
    .smi_gate(smi_gate), .smi_ack(smi_ack), .sci_en(sci_en), .smi(smi)
  );

  AST_PM_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!pm_touch && !$past(pm_touch)) |=> ($stable(pm_base) && $stable(pm_en))); // R4
  AST_SMB_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!smb_touch && !$past(smb_touch)) |=> ($stable(smb_base) && $stable(smb_en))); // R5
  AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (pm_base[WIN_BITS-1:0] == '0) && (smb_base[WIN_BITS-1:0] == '0)); // R4

endmodule

// File: tb/test_pm_cfg_front.sv
module test_pm_cfg_front;

  localparam logic [15:0] VID = 16'ha5c3;
  localparam logic [15:0] DID = 16'h7e11;
  localparam logic [15:0] SMB0 = 16'hb100;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        cfg_wr = 0, cfg_rd = 0;
  logic [5:0]  cfg_dw = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic        io_valid = 0;
  logic [15:0] io_addr = 0;
  logic        apm_wr = 0, smi_ack = 0;
  logic [7:0]  apm_data = 0;

  logic [31:0] rdata, rdata2;
  logic        pm_en, pm_hit, smb_en, smb_hit, sci_en, smi;
  logic [15:0] pm_base, smb_base;
  logic        pm_en2, pm_hit2, smb_en2, smb_hit2, sci_en2, smi2;
  logic [15:0] pm_base2, smb_base2;

  pm_cfg_front #(.SMM_SUPPORT(1'b0), .VENDOR_ID(VID), .DEVICE_ID(DID),
                 .SMB_BASE_INIT(SMB0)) i_pm_cfg_front (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata),
    .io_valid(io_valid), .io_addr(io_addr),
    .pm_en(pm_en), .pm_base(pm_base), .pm_hit(pm_hit),
    .smb_en(smb_en), .smb_base(smb_base), .smb_hit(smb_hit),
    .apm_wr(apm_wr), .apm_data(apm_data), .smi_ack(smi_ack),
    .sci_en(sci_en), .smi(smi));

  pm_cfg_front #(.SMM_SUPPORT(1'b1), .VENDOR_ID(VID), .DEVICE_ID(DID),
                 .SMB_BASE_INIT(SMB0)) i_pm_cfg_front_smm (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata2),
    .io_valid(io_valid), .io_addr(io_addr),
    .pm_en(pm_en2), .pm_base(pm_base2), .pm_hit(pm_hit2),
    .smb_en(smb_en2), .smb_base(smb_base2), .smb_hit(smb_hit2),
    .apm_wr(apm_wr), .apm_data(apm_data), .smi_ack(smi_ack),
    .sci_en(sci_en2), .smi(smi2));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic cfg_read(logic [5:0] dw, output logic [31:0] v, output logic [31:0] v2);
    @(negedge clk);
    cfg_rd = 1; cfg_dw = dw;
    @(negedge clk);
    cfg_rd = 0;
    v = rdata; v2 = rdata2;
  endtask

  task automatic io_probe(logic [15:0] a);
    @(negedge clk);
    io_valid = 1; io_addr = a;
    @(negedge clk);
    io_valid = 0;
  endtask

  task automatic apm_cmd(logic [7:0] c, logic ack);
    @(negedge clk);
    apm_wr = 1; apm_data = c; smi_ack = ack;
    @(negedge clk);
    apm_wr = 0; smi_ack = 0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v, v2;
    check("R5 smb_en reset", smb_en, 1);
    check("R5 smb_base reset", smb_base, SMB0);
    check("R4 pm_en reset", pm_en, 0);
    check("R7 sci_en reset", sci_en, 0);
    cfg_read(6'd1, v, v2);  check("R1 bytes 06/07", v[31:16], 16'h0280);
    cfg_read(6'd2, v, v2);  check("R1 revision", v[7:0], 8'h03);
    cfg_read(6'd15, v, v2); check("R1 int pin", v[15:8], 8'h01);
    cfg_read(6'd16, v, v2); check("R1 byte 40", v, 32'h1);
    cfg_read(6'd32, v, v2); check("R1 byte 80", v, 32'h0);
    cfg_read(6'd36, v, v2); check("R1 smb base dword", v, 32'h0000_b101);
    cfg_read(6'd52, v, v2); check("R1 byte d2", v, 32'h0009_0000);
    cfg_read(6'd22, v, v2);
    check("R1 bytes 58..5a", v[23:0], 24'h0);
    check("R10 byte 5b no SMM", v[31:24], 8'h02);
    check("R10 byte 5b with SMM", v2[31:24], 8'h00);
  endtask

  task automatic t_byte_lanes();
    logic [31:0] v, v2;
    cfg_write(6'd48, 4'b0101, 32'haabbccdd);
    cfg_read(6'd48, v, v2); check("R2 lanes 0 and 2", v, 32'h00bb00dd);
    cfg_write(6'd48, 4'b1000, 32'h11223344);
    cfg_read(6'd48, v, v2); check("R2 lane 3", v, 32'h11bb00dd);
    repeat (3) @(negedge clk);
    check("R2 rdata held", rdata, 32'h11bb00dd);
  endtask

  task automatic t_read_only();
    logic [31:0] v, v2;
    cfg_write(6'd0, 4'hf, 32'hffffffff);
    cfg_read(6'd0, v, v2); check("R3 identity", v, {DID, VID});
    cfg_write(6'd2, 4'hf, 32'h0);
    cfg_read(6'd2, v, v2); check("R3 class/rev", v, 32'h0680_0003);
    cfg_write(6'd15, 4'hf, 32'h0000_0055);
    cfg_read(6'd15, v, v2); check("R3 int pin kept, line written", v, 32'h0000_0155);
    cfg_write(6'd16, 4'hf, 32'h0);
    cfg_read(6'd16, v, v2); check("R3 pm marker bit", v, 32'h1);
    cfg_write(6'd36, 4'b0001, 32'h0);
    cfg_read(6'd36, v, v2); check("R3 smb marker bit", v, 32'h0000_b101);
  endtask

  task automatic t_pm_window();
    cfg_write(6'd16, 4'b0011, 32'h0000_403f);
    check("R4 base not yet latched", pm_base, 16'h0000);
    @(negedge clk);
    check("R4 base latched masked", pm_base, 16'h4000);
    check("R4 still disabled", pm_en, 0);
    io_probe(16'h4010); check("R6 disabled no hit", pm_hit, 0);
    cfg_write(6'd32, 4'b0001, 32'h1); settle();
    check("R4 enabled", pm_en, 1);
    io_probe(16'h4010); check("R6 pm hit", pm_hit, 1);
    check("R6 no smb hit", smb_hit, 0);
    io_probe(16'h4040); check("R6 outside window", pm_hit, 0);
    cfg_write(6'd17, 4'hf, 32'h0000_0001); settle();
    check("R4 neighbour untouched", pm_base, 16'h4000);
    cfg_write(6'd32, 4'b0001, 32'h0); settle();
    check("R4 disabled again", pm_en, 0);
    io_probe(16'h4010); check("R6 after disable", pm_hit, 0);
  endtask

  task automatic t_smb_window();
    io_probe(16'hb13f); check("R6 smb hit at reset base", smb_hit, 1);
    cfg_write(6'd36, 4'b0011, 32'h0000_c27f); settle();
    check("R5 smb base moved", smb_base, 16'hc240);
    io_probe(16'hc250); check("R6 smb hit new base", smb_hit, 1);
    io_probe(16'hb110); check("R6 old base no hit", smb_hit, 0);
    cfg_write(6'd52, 4'b0100, 32'h0); settle();
    check("R5 smb disabled", smb_en, 0);
    io_probe(16'hc250); check("R6 smb disabled no hit", smb_hit, 0);
  endtask

  task automatic t_apm();
    apm_cmd(8'hf1, 0);
    check("R7 sci set", sci_en, 1); check("R7 no smi on enable", smi, 0);
    apm_cmd(8'hf0, 0);
    check("R7 sci clear", sci_en, 0); check("R7 no smi on disable", smi, 0);
    apm_cmd(8'h55, 0);
    check("R8 smi raised", smi, 1); check("R8 sci untouched", sci_en, 0);
    check("R10 smm instance no smi", smi2, 0);
    repeat (3) @(negedge clk);
    check("R9 smi held", smi, 1);
    @(negedge clk); smi_ack = 1; @(negedge clk); smi_ack = 0;
    check("R9 smi acked", smi, 0);
    apm_cmd(8'h12, 1);
    check("R9 raise beats ack", smi, 1);
    @(negedge clk); smi_ack = 1; @(negedge clk); smi_ack = 0;
    cfg_write(6'd22, 4'b1000, 32'h0);
    apm_cmd(8'h55, 0);
    check("R8 gate off no smi", smi, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset_state();
    t_byte_lanes();
    t_read_only();
    t_pm_window();
    t_smb_window();
    t_apm();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule